// File: doc/BRIEF.md
# Descriptor-Chained Pixel Streaming Engine

This engine moves one whole frame of 16-bit pixels out of a word-readable buffer and presents each pixel on two byte-wide output registers. Every strobe from the pixel clock moves one two-byte burst. The block reads one word from a synchronous RAM. One cycle later it loads the low byte into one output register and the high byte into the other, both on the same edge.

The frame is cut into a fixed chain of `DESC_COUNT` equal descriptors. Each descriptor covers `DESC_BYTES` bytes. A descriptor never exceeds `MAX_DESC_BYTES`: a larger setting is clamped to that limit and then rounded down to a whole number of bursts. With the defaults, 64 descriptors of 4080 bytes cover a 480 x 272 frame, which is 130560 pixels or 261120 bytes. Setting 68 descriptors of 3840 bytes gives the same frame.

The chain steps from one descriptor to the next by itself. It stops after the final burst of the last descriptor, with no terminate input. It stays stopped until a new start pulse arrives. A request that arrives while a read is still in flight is dropped and recorded in a sticky underrun flag.

Top module: `pix_stream_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `underrun_o` and `rd_en_o` are 0, both byte outputs are 0, and `desc_idx_o` is 0.
- R2: A `start_i` pulse while idle begins a frame: `busy_o` rises on that edge, `desc_idx_o` returns to 0, `underrun_o` clears, and the first burst reads from `BASE_ADDR`. A `start_i` pulse while busy has no effect: the address sequence and `desc_idx_o` carry on unchanged.
- R3: A request accepted while busy raises `rd_en_o` in the same cycle. The byte address is `BASE_ADDR + 2*k` for the k-th burst of the frame (counting from 0), so the address grows by 2 per burst.
- R4: On the edge after a read, `lo_byte_o` takes bits 7:0 of `rd_data_i` and `hi_byte_o` takes bits 15:8. Both registers load on that same edge.
- R5: The descriptor length is `DESC_BYTES`, clamped to `MAX_DESC_BYTES` and rounded down to an even count. `desc_idx_o` advances on the edge that issues the last burst of a descriptor. The next descriptor starts on the very next request, and no pixel is skipped or repeated.
- R6: One frame is `DESC_COUNT` descriptors. After the final burst, requests cause no read, the byte outputs hold, and `desc_idx_o` stays at `DESC_COUNT-1` until restart.
- R7: `done_o` is high for exactly one cycle. It is set on the edge that loads the final burst's bytes, and `busy_o` falls on that same edge.
- R8: A request that arrives while the previous read is pending causes no read and leaves the byte outputs unchanged. It sets `underrun_o`, which stays high until the next accepted start.
- R9: Requests while idle cause no read and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one frame |
| req_i | input | 1 | Pixel-clock transfer request strobe |
| rd_en_o | output | 1 | RAM read enable |
| rd_addr_o | output | ADDR_W | RAM byte address of the burst |
| rd_data_i | input | 16 | RAM read word, valid one cycle after `rd_en_o` |
| lo_byte_o | output | 8 | Output register for the low byte |
| hi_byte_o | output | 8 | Output register for the high byte |
| desc_idx_o | output | DESC_W | Index of the current descriptor |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the frame completes |
| underrun_o | output | 1 | Sticky flag for a request that was dropped |

## Verification
Frame completion and the underrun detector can act on the same edge. This happens when a request arrives in the cycle where the final burst's bytes are being loaded. The bench provokes it by holding the request high for two cycles on the last pixel of a frame. It then expects, after that edge, `done_o` high for one cycle, `busy_o` low, `underrun_o` set, and no extra read. The byte outputs must still hold the final pixel. A second held request in the middle of a frame, next to a start pulse sent while busy, checks that a dropped request neither shifts the address sequence nor disturbs the descriptor count.

// File: rtl/pse_pkg.sv
package pse_pkg;

  localparam int LANE_W      = 8;
  localparam int LANES       = 2;
  localparam int BURST_BYTES = LANES;

  // Clamp a requested descriptor length to the cap, then trim to whole bursts.
  function automatic int clamp_len(input int want, input int cap);
    int v;
    v = (want > cap) ? cap : want;
    return v - (v % BURST_BYTES);
  endfunction

endpackage

// File: rtl/pse_desc_seq.sv
module pse_desc_seq
  import pse_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int BASE_ADDR      = 0,
  parameter int DESC_BYTES     = 4080,
  parameter int MAX_DESC_BYTES = 4095,
  parameter int DESC_COUNT     = 64,
  parameter int DESC_W         = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              issue_i,
  input  logic              capture_i,
  output logic              start_acc_o,
  output logic              busy_o,
  output logic              final_pend_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DESC_W-1:0] desc_idx_o
);

  localparam int EFF_BYTES = clamp_len(DESC_BYTES, MAX_DESC_BYTES);
  localparam int BC_W      = $clog2(MAX_DESC_BYTES + 1);
  localparam logic [BC_W-1:0]   LAST_CNT  = BC_W'(EFF_BYTES - BURST_BYTES);
  localparam logic [BC_W-1:0]   CNT_STEP  = BC_W'(BURST_BYTES);
  localparam logic [DESC_W-1:0] LAST_DESC = DESC_W'(DESC_COUNT - 1);
  localparam logic [ADDR_W-1:0] ADDR_BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BURST_BYTES);

  logic              busy_q, busy_n;
  logic              fin_q, fin_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [BC_W-1:0]   bcnt_q, bcnt_n;
  logic [DESC_W-1:0] desc_q, desc_n;
  logic              start_acc, desc_end, frame_end, seq_en;

  assign start_acc = start_i & ~busy_q;
  assign desc_end  = (bcnt_q == LAST_CNT);
  assign frame_end = desc_end & (desc_q == LAST_DESC);
  assign seq_en    = start_acc | issue_i | (capture_i & fin_q);

  always_comb begin
    busy_n = busy_q;
    fin_n  = fin_q;
    addr_n = addr_q;
    bcnt_n = bcnt_q;
    desc_n = desc_q;
    if (start_acc) begin
      busy_n = 1'b1;
      fin_n  = 1'b0;
      addr_n = ADDR_BASE;
      bcnt_n = '0;
      desc_n = '0;
    end else begin
      if (issue_i) begin
        addr_n = addr_q + ADDR_STEP;
        if (desc_end) begin
          bcnt_n = '0;
          if (frame_end) fin_n = 1'b1;
          else           desc_n = desc_q + 1'b1;
        end else begin
          bcnt_n = bcnt_q + CNT_STEP;
        end
      end
      if (capture_i && fin_q) begin
        busy_n = 1'b0;
        fin_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      addr_q <= '0;
      bcnt_q <= '0;
      desc_q <= '0;
    end else if (seq_en) begin
      busy_q <= busy_n;
      fin_q  <= fin_n;
      addr_q <= addr_n;
      bcnt_q <= bcnt_n;
      desc_q <= desc_n;
    end
  end

  assign start_acc_o  = start_acc;
  assign busy_o       = busy_q;
  assign final_pend_o = fin_q;
  assign addr_o       = addr_q;
  assign desc_idx_o   = desc_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt_q <= LAST_CNT) && !bcnt_q[0]); // R5
  AST_DESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_q <= LAST_DESC); // R6
  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !issue_i); // R9
  AST_FINAL_HOLDS_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q && !start_acc |=> $stable(desc_q)); // R6

endmodule

// File: rtl/pse_burst_ctrl.sv
module pse_burst_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic busy_i,
  input  logic start_acc_i,
  output logic issue_o,
  output logic capture_o,
  output logic underrun_o
);

  logic pend_q, pend_n;
  logic urun_q, urun_n;
  logic issue, urun_en;

  assign issue   = req_i & busy_i & ~pend_q;
  assign urun_en = start_acc_i | (req_i & pend_q);

  always_comb begin
    pend_n = issue;
    urun_n = urun_q;
    if (start_acc_i)          urun_n = 1'b0;
    else if (req_i && pend_q) urun_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       urun_q <= 1'b0;
    else if (urun_en) urun_q <= urun_n;
  end

  assign issue_o    = issue;
  assign capture_o  = pend_q;
  assign underrun_o = urun_q;

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    urun_q && !start_acc_i |=> urun_q); // R8
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue); // R8

endmodule

// File: rtl/pse_lane_regs.sv
module pse_lane_regs
  import pse_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic                    final_i,
  input  logic [LANES*LANE_W-1:0] word_i,
  output logic [LANES*LANE_W-1:0] lanes_o,
  output logic                    done_o
);

  logic done_q, done_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lane_q <= '0;
      else if (load_i) lane_q <= word_i[g*LANE_W +: LANE_W];
    end
    assign lanes_o[g*LANE_W +: LANE_W] = lane_q;
  end

  always_comb done_n = load_i & final_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(lanes_o)); // R8

endmodule

// File: rtl/pix_stream_engine.sv
module pix_stream_engine
  import pse_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int BASE_ADDR      = 0,
  parameter int DESC_BYTES     = 4080,
  parameter int MAX_DESC_BYTES = 4095,
  parameter int DESC_COUNT     = 64,
  parameter int DESC_W         = $clog2(DESC_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              req_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [15:0]       rd_data_i,
  output logic [7:0]        lo_byte_o,
  output logic [7:0]        hi_byte_o,
  output logic [DESC_W-1:0] desc_idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              underrun_o
);

  logic                    start_acc, busy, final_pend;
  logic                    issue, capture;
  logic [LANES*LANE_W-1:0] lanes;

  pse_desc_seq #(
    .ADDR_W         (ADDR_W),
    .BASE_ADDR      (BASE_ADDR),
    .DESC_BYTES     (DESC_BYTES),
    .MAX_DESC_BYTES (MAX_DESC_BYTES),
    .DESC_COUNT     (DESC_COUNT),
    .DESC_W         (DESC_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .issue_i      (issue),
    .capture_i    (capture),
    .start_acc_o  (start_acc),
    .busy_o       (busy),
    .final_pend_o (final_pend),
    .addr_o       (rd_addr_o),
    .desc_idx_o   (desc_idx_o)
  );

  pse_burst_ctrl u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .busy_i      (busy),
    .start_acc_i (start_acc),
    .issue_o     (issue),
    .capture_o   (capture),
    .underrun_o  (underrun_o)
  );

  pse_lane_regs u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (capture),
    .final_i (final_pend),
    .word_i  (rd_data_i),
    .lanes_o (lanes),
    .done_o  (done_o)
  );

  assign rd_en_o   = issue;
  assign lo_byte_o = lanes[7:0];
  assign hi_byte_o = lanes[15:8];
  assign busy_o    = busy;

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R7
  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> busy_o); // R9
  AST_ADDR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(rd_addr_o)); // R6

endmodule

// File: tb/pix_stream_engine_bench.sv
module pix_stream_engine_bench;

  localparam int AW    = 8;
  localparam int BASE  = 16;
  localparam int PX_D  = 5;   // 14 requested, capped at 10 bytes -> 5 bursts
  localparam int NDESC = 4;
  localparam int NPX   = PX_D * NDESC;

  logic          clk, rst_n, start_i, req_i;
  logic          rd_en_o, busy_o, done_o, underrun_o;
  logic [AW-1:0] rd_addr_o;
  logic [15:0]   rd_data_i;
  logic [7:0]    lo_byte_o, hi_byte_o;
  logic [1:0]    desc_idx_o;

  int checks, errors;
  bit finished;

  pix_stream_engine #(
    .ADDR_W(AW), .BASE_ADDR(BASE), .DESC_BYTES(14),
    .MAX_DESC_BYTES(10), .DESC_COUNT(NDESC), .DESC_W(2)
  ) u_pix_stream_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .lo_byte_o(lo_byte_o), .hi_byte_o(hi_byte_o), .desc_idx_o(desc_idx_o),
    .busy_o(busy_o), .done_o(done_o), .underrun_o(underrun_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Synchronous RAM model: the word at byte address a is {a ^ 8'h5A, a}.
  always_ff @(posedge clk)
    if (rd_en_o) rd_data_i <= {rd_addr_o ^ 8'h5A, rd_addr_o};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // One burst for pixel k. With hold set, the request stays high one more cycle.
  task automatic pixel(input int k, input bit hold, input bit urun_exp);
    int a, di;
    a  = BASE + 2 * k;
    di = (k + 1) / PX_D;
    if (di > NDESC - 1) di = NDESC - 1;
    @(negedge clk);
    chk("R7 done low between bursts", done_o, 0);
    req_i = 1'b1;
    #1;
    chk("R3 read enable", rd_en_o, 1);
    chk("R3 read address", rd_addr_o, a);
    @(negedge clk);
    if (hold) begin
      #1;
      chk("R8 no read while pending", rd_en_o, 0);
      @(negedge clk);
    end
    req_i = 1'b0;
    if (!hold) @(negedge clk);
    chk("R4 low byte", lo_byte_o, a & 8'hFF);
    chk("R4 high byte", hi_byte_o, (a ^ 8'h5A) & 8'hFF);
    chk("R5 descriptor index", desc_idx_o, di);
    chk("R7 done pulse", done_o, (k == NPX - 1) ? 1 : 0);
    chk("R7 busy", busy_o, (k == NPX - 1) ? 0 : 1);
    chk("R8 underrun flag", underrun_o, urun_exp ? 1 : 0);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; start_i = 1'b0; req_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 underrun", underrun_o, 0);
    chk("R1 read enable", rd_en_o, 0);
    chk("R1 bytes", {hi_byte_o, lo_byte_o}, 0);
    chk("R1 descriptor", desc_idx_o, 0);

    // R9: requests while idle
    req_i = 1'b1; #1;
    chk("R9 idle read", rd_en_o, 0);
    @(negedge clk); req_i = 1'b0; @(negedge clk);
    chk("R9 idle bytes", {hi_byte_o, lo_byte_o}, 0);

    // Frame 1: underrun at pixel 7, start while busy before pixel 10
    pulse_start();
    chk("R2 busy after start", busy_o, 1);
    chk("R2 descriptor zero", desc_idx_o, 0);
    for (int k = 0; k < NPX; k++) begin
      if (k == 10) begin
        pulse_start();
        chk("R2 start while busy ignored", desc_idx_o, 2);
      end
      pixel(k, k == 7, k >= 7);
    end
    @(negedge clk);
    chk("R7 done falls", done_o, 0);
    // R6: after completion, a request is ignored
    req_i = 1'b1; #1;
    chk("R6 no read after frame", rd_en_o, 0);
    @(negedge clk); req_i = 1'b0; @(negedge clk);
    chk("R6 bytes hold", lo_byte_o, (BASE + 2 * (NPX - 1)) & 8'hFF);
    chk("R6 descriptor holds", desc_idx_o, NDESC - 1);

    // Frame 2: restart, request overlapping the final load
    pulse_start();
    chk("R2 underrun cleared", underrun_o, 0);
    chk("R2 restart descriptor", desc_idx_o, 0);
    for (int k = 0; k < NPX; k++) pixel(k, k == NPX - 1, k == NPX - 1);
    @(negedge clk);
    chk("R7 single done", done_o, 0);
    chk("R8 final bytes held", hi_byte_o, ((BASE + 2 * (NPX - 1)) ^ 8'h5A) & 8'hFF);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule